// File: doc/BRIEF.md
# Framed Sample-Stream Serializer

The block gathers a 4-bit quantizer sample (I sign, I magnitude, Q sign, Q magnitude) on every sample strobe. It collects sixteen samples into one slice per bit position, and then sends the selected bit positions out on a single serial data line. Each bit position goes out as a 16-bit segment. The segments follow one another in a fixed order. A data-sync flag can mark the first bit of every segment. A time-sync pulse marks a programmable number of samples. A frame counter numbers the slices, and the block can place that number in front of each slice's data.

Streaming is controlled by a master enable and by edge-triggered start and stop commands. When the enable rises and no start command follows, the block arms itself and begins sending at the slice whose number equals a programmed frame value. A clear command resets every counter and aborts a transfer that is in progress. The whole block runs from one clock. Two strobes, sample-enable and serial-enable, pace the two halves. A sticky flag reports a slice that arrived while the previous slice was still being sent.

Top module: `sample_lane_serializer`

## Requirements
- R1: While reset is asserted and after it is released, `ser_dat`, `dat_sync`, `time_sync` and `ovr_err` are 0.
- R2: Sixteen consecutive samples taken on `smp_en` make one slice, and the sample count starts at 0 after any counter clear. Within a lane segment, the oldest sample is sent first.
- R3: `lane_mix` selects the lanes sent. Code 0 sends lane 0 only. Code 1 sends lane 0 then lane 1. Code 2 sends lane 0 then lane 2. Code 3 sends lanes 0, 1, 2 and 3 in that order. Lane n is `smp_bits[n]`. The setting is taken when a slice is accepted for sending.
- R4: With `stamp_en` set when a slice is accepted, two 16-bit segments go out before its lanes. Together they carry the slice's frame number as a 32-bit value, most significant bit first, with the upper 4 bits zero. The slice counted first after a clear is number 0.
- R5: After the last bit of a slice, every further serial strobe drives `ser_dat` to 0 until the next accepted slice.
- R6: `ser_dat` and `dat_sync` change only in the cycle after a `ser_en` cycle. `ser_dat` holds its value otherwise.
- R7: With `sync_en` set, `dat_sync` is high for one cycle together with the first bit of each segment. With `sync_en` clear, `dat_sync` stays 0.
- R8: A rising edge of `start_cmd` while `stream_on` is high makes every later completed slice be sent. A rising edge of `stop_cmd` stops new slices from being accepted, and the slice in flight completes.
- R9: A rising edge of `stream_on` clears the frame and sample counters. If no start command follows, the first slice sent is the one whose frame number equals `start_frame`, and every later slice is sent as well.
- R10: `clr_cmd` clears the frame, sample and time-sync counters and abandons the slice in flight. After the next serial strobe, `ser_dat` reads 0.
- R11: `time_sync` pulses for one cycle on every (128 << `tsync_len`)-th sample counted from the last counter clear.
- R12: Time-sync pulses appear while streaming is active. With `tsync_en` set, they also appear whenever `stream_on` is high. In all other cases they are suppressed.
- R13: `ovr_err` goes to 1 and stays there when a slice is accepted while the previous one is still being sent. Either `clr_cmd` or a rising edge of `stream_on` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | Sample strobe |
| smp_bits | input | 4 | Quantizer bits, lanes 0 to 3 |
| ser_en | input | 1 | Serial bit strobe |
| lane_mix | input | 2 | Lane selection code |
| stream_on | input | 1 | Master streaming enable |
| start_cmd | input | 1 | Start command, rising-edge active |
| stop_cmd | input | 1 | Stop command, rising-edge active |
| clr_cmd | input | 1 | Counter clear and transfer abort |
| start_frame | input | 28 | Frame number for armed start |
| stamp_en | input | 1 | Insert frame number segments |
| sync_en | input | 1 | Enable segment data-sync flag |
| tsync_en | input | 1 | Time-sync whenever enabled, not only while streaming |
| tsync_len | input | 3 | Time-sync period code |
| ser_dat | output | 1 | Serial data line |
| dat_sync | output | 1 | Segment-start flag |
| time_sync | output | 1 | Time-sync pulse |
| ovr_err | output | 1 | Sticky overrun flag |

## Verification
The hardest state to reach is the armed start: `stream_on` must rise with no start command, and the block must then wait several whole slices before the numbered one goes out. The bench drops and raises `stream_on` with `start_frame` set to 3, then runs long enough for the frame counter to pass that number, so the line is checked to stay quiet first and carry data afterwards. An overrun needs a slice period shorter than the bits it must carry. The bench builds one by sending all lanes with stamping at a fast sample rate. A behavioural model, built from sample and bit queues, predicts every output in every cycle.

// File: rtl/sls_pkg.sv
package sls_pkg;

  localparam int NUM_LANES = 4;

  typedef enum logic [1:0] {
    MIX_B0    = 2'b00,
    MIX_B0_B1 = 2'b01,
    MIX_B0_B2 = 2'b10,
    MIX_ALL   = 2'b11
  } lane_mix_e;

  // number of lane segments sent for a mix code
  function automatic int mix_lanes(lane_mix_e m);
    case (m)
      MIX_B0:  return 1;
      MIX_ALL: return 4;
      default: return 2;
    endcase
  endfunction

  // lane index carried by the k-th lane segment
  function automatic int mix_pick(lane_mix_e m, int k);
    if (k == 0) return 0;
    if (m == MIX_B0_B2) return 2;
    return k;
  endfunction

endpackage

// File: rtl/sls_capture.sv
module sls_capture #(
  parameter int SEG_W = 16,
  parameter int NLANE = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        smp_en,
  input  logic                        clr,
  input  logic [NLANE-1:0]            smp_bits,
  output logic                        load,
  output logic [NLANE-1:0][SEG_W-1:0] slice
);
  localparam int IDX_W = $clog2(SEG_W);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             last;

  assign last = (idx_q == IDX_W'(SEG_W - 1));
  assign load = smp_en & last & ~clr;

  always_comb begin
    idx_d = idx_q;
    if (clr)         idx_d = '0;
    else if (smp_en) idx_d = last ? '0 : idx_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  // one holding register per lane; the oldest sample ends at the MSB
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [SEG_W-1:0] hold_q;
    logic [SEG_W-1:0] hold_d;

    assign hold_d   = {hold_q[SEG_W-2:0], smp_bits[g]};
    assign slice[g] = hold_d;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hold_q <= '0;
      else if (smp_en) hold_q <= hold_d;
    end
  end

endmodule

// File: rtl/sls_control.sv
module sls_control #(
  parameter int FRAME_W = 28,
  parameter int TSL_W   = 3,
  parameter int TS_BASE = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stream_on,
  input  logic               start_cmd,
  input  logic               stop_cmd,
  input  logic               clr_cmd,
  input  logic [FRAME_W-1:0] start_frame,
  input  logic               tsync_en,
  input  logic [TSL_W-1:0]   tsync_len,
  input  logic               smp_en,
  input  logic               load,
  output logic               clr_all,
  output logic               fire,
  output logic [FRAME_W-1:0] frame_no,
  output logic               time_sync
);
  localparam int TS_W = TS_BASE + (1 << TSL_W) - 1;

  logic               on_q, start_q, stop_q;
  logic               on_rise, start_rise, stop_rise;
  logic               active_q, active_d, armed_q, armed_d;
  logic               match;
  logic [FRAME_W-1:0] fcnt_q, fcnt_d;
  logic [TS_W-1:0]    tcnt_q, tcnt_d, per_m1;
  logic [TS_W:0]      per_sh;
  logic               wrap, ts_d;

  assign on_rise    = stream_on & ~on_q;
  assign start_rise = start_cmd & ~start_q;
  assign stop_rise  = stop_cmd & ~stop_q;
  assign clr_all    = clr_cmd | on_rise;

  assign match    = armed_q & (fcnt_q == start_frame);
  assign fire     = load & stream_on & (active_q | match);
  assign frame_no = fcnt_q;

  // streaming state: stop over start over arming over armed match
  always_comb begin
    active_d = active_q;
    armed_d  = armed_q;
    if (!stream_on) begin
      active_d = 1'b0;
      armed_d  = 1'b0;
    end else if (stop_rise) begin
      active_d = 1'b0;
      armed_d  = 1'b0;
    end else if (start_rise) begin
      active_d = 1'b1;
      armed_d  = 1'b0;
    end else if (on_rise) begin
      armed_d  = 1'b1;
    end else if (load && match) begin
      active_d = 1'b1;
      armed_d  = 1'b0;
    end
  end

  always_comb begin
    fcnt_d = fcnt_q;
    if (clr_all)   fcnt_d = '0;
    else if (load) fcnt_d = fcnt_q + FRAME_W'(1);
  end

  // time-sync period = 2^(TS_BASE + tsync_len) samples
  assign per_sh = (TS_W + 1)'(1) << (TS_BASE + int'(tsync_len));
  assign per_m1 = TS_W'(per_sh - (TS_W + 1)'(1));
  assign wrap   = (tcnt_q >= per_m1);

  always_comb begin
    tcnt_d = tcnt_q;
    if (clr_all)     tcnt_d = '0;
    else if (smp_en) tcnt_d = wrap ? '0 : tcnt_q + TS_W'(1);
  end

  assign ts_d = ~clr_all & smp_en & wrap & ((tsync_en & stream_on) | active_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q      <= 1'b0;
      start_q   <= 1'b0;
      stop_q    <= 1'b0;
      active_q  <= 1'b0;
      armed_q   <= 1'b0;
      fcnt_q    <= '0;
      tcnt_q    <= '0;
      time_sync <= 1'b0;
    end else begin
      on_q      <= stream_on;
      start_q   <= start_cmd;
      stop_q    <= stop_cmd;
      active_q  <= active_d;
      armed_q   <= armed_d;
      fcnt_q    <= fcnt_d;
      tcnt_q    <= tcnt_d;
      time_sync <= ts_d;
    end
  end

endmodule

// File: rtl/sls_shifter.sv
module sls_shifter
  import sls_pkg::*;
#(
  parameter int SEG_W   = 16,
  parameter int NLANE   = 4,
  parameter int FRAME_W = 28
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr_all,
  input  logic                        fire,
  input  logic [NLANE-1:0][SEG_W-1:0] slice,
  input  logic [FRAME_W-1:0]          frame_no,
  input  lane_mix_e                   mix,
  input  logic                        stamp_en,
  input  logic                        sync_en,
  input  logic                        ser_en,
  output logic                        ser_dat,
  output logic                        dat_sync,
  output logic                        ovr_err
);
  localparam int STAMP_SEGS = (FRAME_W + SEG_W - 1) / SEG_W;
  localparam int MAXSEG     = STAMP_SEGS + NLANE;
  localparam int SEGC_W     = $clog2(MAXSEG + 1);
  localparam int SRC_W      = $clog2(MAXSEG);
  localparam int IDX_W      = $clog2(SEG_W);

  logic [STAMP_SEGS*SEG_W-1:0]     stamp_ext;
  logic [MAXSEG-1:0][SEG_W-1:0]    pool;
  logic [MAXSEG-1:0][SEG_W-1:0]    w_new, words_q, words_d;
  logic [SEGC_W-1:0]               nseg_new, nseg_q, nseg_d, seg_q, seg_d;
  logic [IDX_W-1:0]                bit_q, bit_d, bit_pos;
  logic                            busy_q, busy_d, err_d, dat_d, sync_d;
  logic                            cur_bit, last_bit, last_seg;
  int                              st_n, nl_n, src_n;

  assign stamp_ext = (STAMP_SEGS * SEG_W)'(frame_no);

  // candidate segments: stamp words (high first), then the raw lanes
  for (genvar s = 0; s < STAMP_SEGS; s++) begin : g_stamp
    assign pool[s] = stamp_ext[(STAMP_SEGS-1-s)*SEG_W +: SEG_W];
  end
  for (genvar l = 0; l < NLANE; l++) begin : g_pool
    assign pool[STAMP_SEGS+l] = slice[l];
  end

  // segment table for a newly accepted slice
  always_comb begin
    st_n  = stamp_en ? STAMP_SEGS : 0;
    nl_n  = mix_lanes(mix);
    src_n = 0;
    for (int s = 0; s < MAXSEG; s++) begin
      if (s < st_n) begin
        src_n    = s;
        w_new[s] = pool[SRC_W'(src_n)];
      end else if (s - st_n < nl_n) begin
        src_n    = STAMP_SEGS + mix_pick(mix, s - st_n);
        w_new[s] = pool[SRC_W'(src_n)];
      end else begin
        w_new[s] = '0;
      end
    end
    nseg_new = SEGC_W'(st_n + nl_n);
  end

  assign bit_pos  = IDX_W'(SEG_W - 1) - bit_q;
  assign cur_bit  = words_q[seg_q][bit_pos];
  assign last_bit = (bit_q == IDX_W'(SEG_W - 1));
  assign last_seg = (seg_q == nseg_q - SEGC_W'(1));

  always_comb begin
    words_d = words_q;
    nseg_d  = nseg_q;
    seg_d   = seg_q;
    bit_d   = bit_q;
    busy_d  = busy_q;
    err_d   = ovr_err;
    if (clr_all) begin
      busy_d = 1'b0;
      seg_d  = '0;
      bit_d  = '0;
      err_d  = 1'b0;
    end else if (fire) begin
      words_d = w_new;
      nseg_d  = nseg_new;
      seg_d   = '0;
      bit_d   = '0;
      busy_d  = 1'b1;
      err_d   = ovr_err | busy_q;
    end else if (ser_en && busy_q) begin
      bit_d = bit_q + IDX_W'(1);
      if (last_bit) begin
        seg_d = seg_q + SEGC_W'(1);
        if (last_seg) busy_d = 1'b0;
      end
    end
  end

  // line outputs move only on serial strobes
  always_comb begin
    dat_d  = ser_dat;
    sync_d = 1'b0;
    if (ser_en) begin
      dat_d  = busy_q & cur_bit;
      sync_d = busy_q & sync_en & (bit_q == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words_q  <= '0;
      nseg_q   <= '0;
      seg_q    <= '0;
      bit_q    <= '0;
      busy_q   <= 1'b0;
      ovr_err  <= 1'b0;
      ser_dat  <= 1'b0;
      dat_sync <= 1'b0;
    end else begin
      words_q  <= words_d;
      nseg_q   <= nseg_d;
      seg_q    <= seg_d;
      bit_q    <= bit_d;
      busy_q   <= busy_d;
      ovr_err  <= err_d;
      ser_dat  <= dat_d;
      dat_sync <= sync_d;
    end
  end

endmodule

// File: rtl/sample_lane_serializer.sv
module sample_lane_serializer
  import sls_pkg::*;
#(
  parameter int SEG_W   = 16,
  parameter int FRAME_W = 28,
  parameter int TSL_W   = 3,
  parameter int TS_BASE = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_en,
  input  logic [3:0]         smp_bits,
  input  logic               ser_en,
  input  logic [1:0]         lane_mix,
  input  logic               stream_on,
  input  logic               start_cmd,
  input  logic               stop_cmd,
  input  logic               clr_cmd,
  input  logic [FRAME_W-1:0] start_frame,
  input  logic               stamp_en,
  input  logic               sync_en,
  input  logic               tsync_en,
  input  logic [TSL_W-1:0]   tsync_len,
  output logic               ser_dat,
  output logic               dat_sync,
  output logic               time_sync,
  output logic               ovr_err
);
  logic                            clr_all, load, fire;
  logic [NUM_LANES-1:0][SEG_W-1:0] slice;
  logic [FRAME_W-1:0]              frame_no;

  sls_capture #(.SEG_W(SEG_W), .NLANE(NUM_LANES)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_en   (smp_en),
    .clr      (clr_all),
    .smp_bits (smp_bits),
    .load     (load),
    .slice    (slice)
  );

  sls_control #(.FRAME_W(FRAME_W), .TSL_W(TSL_W), .TS_BASE(TS_BASE)) u_control (
    .clk         (clk),
    .rst_n       (rst_n),
    .stream_on   (stream_on),
    .start_cmd   (start_cmd),
    .stop_cmd    (stop_cmd),
    .clr_cmd     (clr_cmd),
    .start_frame (start_frame),
    .tsync_en    (tsync_en),
    .tsync_len   (tsync_len),
    .smp_en      (smp_en),
    .load        (load),
    .clr_all     (clr_all),
    .fire        (fire),
    .frame_no    (frame_no),
    .time_sync   (time_sync)
  );

  sls_shifter #(.SEG_W(SEG_W), .NLANE(NUM_LANES), .FRAME_W(FRAME_W)) u_shifter (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_all  (clr_all),
    .fire     (fire),
    .slice    (slice),
    .frame_no (frame_no),
    .mix      (lane_mix_e'(lane_mix)),
    .stamp_en (stamp_en),
    .sync_en  (sync_en),
    .ser_en   (ser_en),
    .ser_dat  (ser_dat),
    .dat_sync (dat_sync),
    .ovr_err  (ovr_err)
  );

endmodule

// File: rtl/sls_checker.sv
module sls_checker (
  input logic clk,
  input logic rst_n,
  input logic smp_en,
  input logic ser_en,
  input logic sync_en,
  input logic clr_cmd,
  input logic ser_dat,
  input logic dat_sync,
  input logic time_sync,
  input logic ovr_err
);
  AST_SYNC_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    dat_sync |-> $past(ser_en)); // R7
  AST_SYNC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    dat_sync |-> $past(sync_en)); // R7
  AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ser_en) |-> $stable(ser_dat)); // R6
  AST_TSYNC_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    time_sync |-> $past(smp_en)); // R11
  AST_TSYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    time_sync |=> !time_sync); // R11
  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_cmd) |-> !ovr_err); // R13
  AST_CLR_NO_TSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_cmd) |-> !time_sync); // R10
endmodule

bind sample_lane_serializer sls_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_en    (smp_en),
  .ser_en    (ser_en),
  .sync_en   (sync_en),
  .clr_cmd   (clr_cmd),
  .ser_dat   (ser_dat),
  .dat_sync  (dat_sync),
  .time_sync (time_sync),
  .ovr_err   (ovr_err)
);

// File: tb/sample_lane_serializer_tb.sv
`timescale 1ns/1ps
module sample_lane_serializer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_en, ser_en, stream_on, start_cmd, stop_cmd, clr_cmd;
  logic        stamp_en, sync_en, tsync_en;
  logic [3:0]  smp_bits;
  logic [1:0]  lane_mix;
  logic [27:0] start_frame;
  logic [2:0]  tsync_len;
  logic        ser_dat, dat_sync, time_sync, ovr_err;

  always #2.5 clk = ~clk;

  sample_lane_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .smp_bits(smp_bits),
    .ser_en(ser_en), .lane_mix(lane_mix), .stream_on(stream_on),
    .start_cmd(start_cmd), .stop_cmd(stop_cmd), .clr_cmd(clr_cmd),
    .start_frame(start_frame), .stamp_en(stamp_en), .sync_en(sync_en),
    .tsync_en(tsync_en), .tsync_len(tsync_len), .ser_dat(ser_dat),
    .dat_sync(dat_sync), .time_sync(time_sync), .ovr_err(ovr_err)
  );

  int    errs = 0, checks = 0, wd = 0, cyc = 0;
  int    smp_div = 4, ser_div = 1;
  bit    gen_on = 0, cmp_on = 0;
  string tag = "R1";

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // strobe and sample generator
  always @(negedge clk) begin
    if (gen_on) begin
      cyc++;
      smp_en   = (cyc % smp_div) == 0;
      ser_en   = (cyc % ser_div) == 0;
      smp_bits = 4'($urandom);
    end
  end

  // ---------------- behavioural reference model ----------------
  logic [3:0]  smpq[$];
  bit          txq[$], txf[$];
  logic [27:0] m_fcnt;
  bit          m_active, m_armed, p_on, p_start, p_stop;
  bit          m_dat, m_sync, m_ts, m_err;
  int          tcnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      smpq.delete(); txq.delete(); txf.delete();
      m_fcnt = 0; m_active = 0; m_armed = 0; p_on = 0; p_start = 0; p_stop = 0;
      m_dat = 0; m_sync = 0; m_ts = 0; m_err = 0; tcnt = 0;
    end else begin
      bit on_r, st_r, sp_r, clr, had, load, match, fire, gate;
      int per;
      int lanes[$];
      on_r = stream_on && !p_on;
      st_r = start_cmd && !p_start;
      sp_r = stop_cmd && !p_stop;
      clr  = clr_cmd || on_r;
      had  = txq.size() > 0;
      if (ser_en) begin
        m_dat  = had ? txq[0] : 1'b0;
        m_sync = had && txf[0] && sync_en;
        if (had) begin void'(txq.pop_front()); void'(txf.pop_front()); end
      end else m_sync = 0;
      per  = 128 << tsync_len;
      gate = (tsync_en && stream_on) || m_active;
      if (clr) begin tcnt = 0; m_ts = 0; end
      else if (smp_en) begin
        m_ts = (tcnt >= per - 1) && gate;
        tcnt = (tcnt >= per - 1) ? 0 : tcnt + 1;
      end else m_ts = 0;
      load = 0;
      if (clr) smpq.delete();
      else if (smp_en) begin
        smpq.push_back(smp_bits);
        if (smpq.size() == 16) load = 1;
      end
      match = m_armed && (m_fcnt == start_frame);
      fire  = load && stream_on && (m_active || match);
      if (fire) begin
        txq.delete(); txf.delete();
        if (had) m_err = 1;
        if (stamp_en) begin
          logic [31:0] sv;
          sv = {4'b0, m_fcnt};
          for (int b = 31; b >= 0; b--) begin
            txq.push_back(sv[b]); txf.push_back(b == 31 || b == 15);
          end
        end
        case (lane_mix)
          2'd0: lanes = '{0};
          2'd1: lanes = '{0, 1};
          2'd2: lanes = '{0, 2};
          default: lanes = '{0, 1, 2, 3};
        endcase
        foreach (lanes[k]) begin
          for (int i = 0; i < 16; i++) begin
            txq.push_back(smpq[i][lanes[k]]); txf.push_back(i == 0);
          end
        end
      end
      if (load) smpq.delete();
      if (clr) begin txq.delete(); txf.delete(); m_err = 0; end
      if (clr) m_fcnt = 0; else if (load) m_fcnt = m_fcnt + 1;
      if (!stream_on) begin m_active = 0; m_armed = 0; end
      else if (sp_r) begin m_active = 0; m_armed = 0; end
      else if (st_r) begin m_active = 1; m_armed = 0; end
      else if (on_r) m_armed = 1;
      else if (load && match) begin m_active = 1; m_armed = 0; end
      p_on = stream_on; p_start = start_cmd; p_stop = stop_cmd;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(ser_dat == m_dat, tag, "ser_dat", ser_dat, m_dat);
      chk(dat_sync == m_sync, tag, "dat_sync", dat_sync, m_sync);
      chk(time_sync == m_ts, tag, "time_sync", time_sync, m_ts);
      chk(ovr_err == m_err, tag, "ovr_err", ovr_err, m_err);
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 200000) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", wd);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_start();
    @(negedge clk) start_cmd = 1; @(negedge clk) start_cmd = 0;
  endtask
  task automatic pulse_stop();
    @(negedge clk) stop_cmd = 1; @(negedge clk) stop_cmd = 0;
  endtask
  task automatic pulse_clr();
    @(negedge clk) clr_cmd = 1; @(negedge clk) clr_cmd = 0;
  endtask

  initial begin
    rst_n = 0; smp_en = 0; ser_en = 0; smp_bits = 0; lane_mix = 0;
    stream_on = 0; start_cmd = 0; stop_cmd = 0; clr_cmd = 0; start_frame = 0;
    stamp_en = 0; sync_en = 1; tsync_en = 0; tsync_len = 0;
    run(4);
    // R1 reset state
    chk(ser_dat == 0 && dat_sync == 0, "R1", "line in reset", ser_dat, 0);
    chk(time_sync == 0 && ovr_err == 0, "R1", "flags in reset", ovr_err, 0);
    rst_n = 1;
    run(2);
    chk(ser_dat == 0 && dat_sync == 0 && time_sync == 0 && ovr_err == 0,
        "R1", "outputs after reset", ser_dat, 0);
    cmp_on = 1;
    gen_on = 1;
    stream_on = 1;
    run(3);
    tag = "R3"; lane_mix = 0; smp_div = 4; pulse_start(); run(400);
    tag = "R2"; lane_mix = 1; smp_div = 8; run(600);
    tag = "R3"; lane_mix = 2; run(600);
    lane_mix = 3; run(600);
    tag = "R4"; stamp_en = 1; run(800);
    tag = "R7"; sync_en = 0; run(400);
    sync_en = 1;
    tag = "R6"; stamp_en = 0; lane_mix = 1; ser_div = 2; run(600);
    ser_div = 3; lane_mix = 0; run(600);
    ser_div = 1;
    tag = "R8"; pulse_stop(); run(300);
    tag = "R5"; run(200);
    chk(ser_dat == 0, "R5", "idle line after stop", ser_dat, 0);
    tag = "R8"; pulse_start(); run(400);
    tag = "R9"; stream_on = 0; run(5);
    start_frame = 28'd3; lane_mix = 3; stamp_en = 1; stream_on = 1;
    run(16 * 8 * 6);
    tag = "R10"; run(50); pulse_clr(); run(3);
    chk(ser_dat == 0, "R10", "line after clear", ser_dat, 0);
    run(300);
    tag = "R11"; smp_div = 1; tsync_en = 1; tsync_len = 0; run(600);
    tsync_len = 1; run(800);
    tag = "R12"; pulse_stop(); tsync_en = 1; run(400);
    tsync_en = 0; run(400);
    tag = "R13"; smp_div = 2; lane_mix = 3; stamp_en = 1; pulse_start(); run(200);
    chk(ovr_err == 1, "R13", "overrun flag", ovr_err, 1);
    smp_div = 8; run(300);
    chk(ovr_err == 1, "R13", "overrun flag sticky", ovr_err, 1);
    pulse_clr(); run(2);
    chk(ovr_err == 0, "R13", "overrun flag cleared", ovr_err, 0);
    run(200);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule